// File: doc/BRIEF.md
# Branch Direction History Table

This block predicts the direction of conditional branches for a simple in-order pipeline. It holds a table of small saturating counters. A slice of the fetch address, with the two always-zero low bits removed, selects one counter. The decode stage presents the instruction address, a flag saying whether the instruction is a branch, and the branch's signed word offset. In the same cycle the block answers with a taken or not-taken verdict and the address to fetch next. That address is either the PC-relative branch target or the sequential address four bytes on.

When a branch resolves later in the pipeline, the pipeline sends its address and the real outcome to a separate update port. The selected counter moves one step toward that outcome and stops at either end of its range. The lookup is purely combinational and the table is written on the clock edge. A lookup that meets an update to the same entry in the same cycle therefore sees the counter as it stood before that update.

Top module: `bht_predictor`

## Requirements
- R1: After reset is released, every counter holds the weakly not-taken value 1 (binary 01 for the default 2-bit counter), so every branch lookup predicts not-taken. This holds again after any later reset.
- R2: The entry is selected by PC bits [IDX_W+1:2]. PCs that differ only above bit IDX_W+1 share an entry, and PC bits [1:0] never change which entry is used.
- R3: A counter at its maximum (3 for 2 bits) stays at the maximum on a taken update. From that point one not-taken update still leaves it predicting taken, and a second one makes it predict not-taken.
- R4: A counter at 0 stays at 0 on a not-taken update. One taken update from 0 leaves it predicting not-taken.
- R5: A branch is predicted taken exactly when the most significant bit of its counter is 1. `lk_taken` is never 1 for a non-branch.
- R6: For a taken prediction, `lk_next_pc` equals `lk_pc` plus the offset, where the offset is sign-extended from OFF_W bits and shifted left by two. Both positive and negative offsets behave this way.
- R7: When `lk_is_br` is 0, `lk_next_pc` is `lk_pc + 4` and `lk_taken` is 0, whatever the counter holds.
- R8: A not-taken branch prediction yields `lk_next_pc = lk_pc + 4`.
- R9: If a lookup and an update select the same entry in the same cycle, the lookup reports the counter value from before that update. The update shows in the next cycle.
- R10: An update moves only the selected counter, by exactly one step toward the outcome. With `up_valid` at 0, `up_pc` and `up_taken` have no effect. Other entries are never disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the table is written on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset; loads every counter with weakly not-taken |
| lk_pc | input | ADDR_W | Address of the decoded instruction |
| lk_is_br | input | 1 | Decoded instruction is a conditional branch |
| lk_off | input | OFF_W | Signed word offset of the branch |
| lk_taken | output | 1 | Predicted direction |
| lk_next_pc | output | ADDR_W | Predicted next fetch address |
| up_valid | input | 1 | An update is presented this cycle |
| up_pc | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Real outcome of the resolved branch |

## Verification
A counter that drifts, wraps or is written at the wrong index shows up only as a wrong `lk_taken` and `lk_next_pc` the next time that entry is looked up as a branch. The lookup is combinational, so the fault is visible in the first cycle after the write that caused it. A wrap at either end flips the direction at once, while an off-by-one step shows only after a further one or two updates. The bench therefore walks each counter through its full range, probing after every step. It also probes aliased and neighbouring addresses, and checks the same-cycle collision in the cycle it happens and in the cycle after.

// File: rtl/bht_pkg.sv
package bht_pkg;

   // Widest counter the step function supports.
   localparam int unsigned CTR_MAX_W = 8;

   // One step of a saturating up/down counter with upper bound top.
   function automatic logic [CTR_MAX_W-1:0] sat_step(
      input logic [CTR_MAX_W-1:0] cur,
      input logic                 inc,
      input logic [CTR_MAX_W-1:0] top
   );
      if (inc) return (cur == top) ? cur : cur + 1'b1;
      else     return (cur == '0)  ? cur : cur - 1'b1;
   endfunction

endpackage

// File: rtl/bht_ctr_table.sv
module bht_ctr_table
   import bht_pkg::*;
#(
   parameter int unsigned IDX_W = 12,
   parameter int unsigned CTR_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CTR_W-1:0] rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_inc
);

   localparam int unsigned      DEPTH    = 1 << IDX_W;
   localparam logic [CTR_W-1:0] CTR_TOP  = '1;
   localparam logic [CTR_W-1:0] CTR_INIT = {1'b0, {(CTR_W-1){1'b1}}};

   generate
      if (CTR_W < 2 || CTR_W > CTR_MAX_W) begin : g_bad_ctr
         $error("bht_ctr_table: CTR_W out of range");
      end
      if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
         $error("bht_ctr_table: IDX_W out of range");
      end
   endgenerate

   logic [CTR_W-1:0] ctr_q [DEPTH];
   logic [CTR_W-1:0] wr_old;
   logic [CTR_W-1:0] wr_new;

   assign rd_ctr = ctr_q[rd_idx];
   assign wr_old = ctr_q[wr_idx];

   always_comb begin
      logic [CTR_MAX_W-1:0] stepped;
      stepped = sat_step(CTR_MAX_W'(wr_old), wr_inc, CTR_MAX_W'(CTR_TOP));
      wr_new  = stepped[CTR_W-1:0];
   end

   // One storage cell per entry; each cell decodes its own write strobe.
   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      always_ff @(posedge clk) begin
         if (!rst_n)                                 ctr_q[g] <= CTR_INIT;
         else if (wr_en && wr_idx == IDX_W'(g))      ctr_q[g] <= wr_new;
      end
   end

   // R3: a taken update at the top leaves the entry at the top.
   p_sat_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_inc && wr_old == CTR_TOP) |=> ctr_q[$past(wr_idx)] == CTR_TOP);

   // R4: a not-taken update at zero leaves the entry at zero.
   p_sat_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_inc && wr_old == '0) |=> ctr_q[$past(wr_idx)] == '0);

   // R10: away from the bounds an update moves the entry by one step.
   p_step_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_inc && wr_old != CTR_TOP)
      |=> ctr_q[$past(wr_idx)] == $past(wr_old) + 1'b1);

   p_step_dn_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_inc && wr_old != '0)
      |=> ctr_q[$past(wr_idx)] == $past(wr_old) - 1'b1);

   // R10: without a write strobe the entry being read is left alone.
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ctr_q[$past(rd_idx)] == $past(rd_ctr));

endmodule

// File: rtl/bht_target_gen.sv
module bht_target_gen #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFF_W  = 16
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] seq_pc
);

   logic [ADDR_W-1:0] disp;

   generate
      if (OFF_W < 1) begin : g_bad_off
         $error("bht_target_gen: OFF_W must be positive");
      end
      if (OFF_W + 2 >= ADDR_W) begin : g_trunc
         // The shifted offset already fills the address; keep the low bits.
         logic [OFF_W+1:0] wide;
         assign wide = {off, 2'b00};
         assign disp = wide[ADDR_W-1:0];
      end else begin : g_sext
         assign disp = {{(ADDR_W-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
      end
   endgenerate

   assign target = pc + disp;
   assign seq_pc = pc + ADDR_W'(4);

endmodule

// File: rtl/bht_predictor.sv
module bht_predictor #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = 12,
   parameter int unsigned OFF_W  = 16,
   parameter int unsigned CTR_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_pc,
   input  logic              lk_is_br,
   input  logic [OFF_W-1:0]  lk_off,
   output logic              lk_taken,
   output logic [ADDR_W-1:0] lk_next_pc,
   input  logic              up_valid,
   input  logic [ADDR_W-1:0] up_pc,
   input  logic              up_taken
);

   localparam int unsigned IDX_LO = 2;
   localparam int unsigned IDX_HI = IDX_LO + IDX_W - 1;

   generate
      if (ADDR_W < IDX_W + IDX_LO) begin : g_bad_addr
         $error("bht_predictor: ADDR_W too narrow for IDX_W");
      end
   endgenerate

   logic [IDX_W-1:0]  lk_idx;
   logic [IDX_W-1:0]  up_idx;
   logic [CTR_W-1:0]  lk_ctr;
   logic [ADDR_W-1:0] br_target;
   logic [ADDR_W-1:0] seq_pc;

   assign lk_idx = lk_pc[IDX_HI:IDX_LO];
   assign up_idx = up_pc[IDX_HI:IDX_LO];

   bht_ctr_table #(
      .IDX_W (IDX_W),
      .CTR_W (CTR_W)
   ) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (lk_idx),
      .rd_ctr (lk_ctr),
      .wr_en  (up_valid),
      .wr_idx (up_idx),
      .wr_inc (up_taken)
   );

   bht_target_gen #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W)
   ) u_target (
      .pc     (lk_pc),
      .off    (lk_off),
      .target (br_target),
      .seq_pc (seq_pc)
   );

   assign lk_taken   = lk_is_br & lk_ctr[CTR_W-1];
   assign lk_next_pc = lk_taken ? br_target : seq_pc;

   // R5: only branches are ever predicted taken.
   p_taken_only_br_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lk_taken |-> lk_is_br);

   // R7: a non-branch always falls through.
   p_nonbr_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_is_br |-> (lk_next_pc == lk_pc + ADDR_W'(4)));

   // R8: a not-taken verdict always falls through.
   p_nt_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_taken |-> (lk_next_pc - lk_pc == ADDR_W'(4)));

endmodule

// File: tb/sim_bht_predictor.sv
module sim_bht_predictor;

   localparam int AW = 32;
   localparam int IW = 12;
   localparam int OW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] lk_pc = '0;
   logic          lk_is_br = 1'b0;
   logic [OW-1:0] lk_off = '0;
   logic          lk_taken;
   logic [AW-1:0] lk_next_pc;
   logic          up_valid = 1'b0;
   logic [AW-1:0] up_pc = '0;
   logic          up_taken = 1'b0;

   always #4 clk = ~clk;

   bht_predictor #(.ADDR_W(AW), .IDX_W(IW), .OFF_W(OW), .CTR_W(2)) u0 (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_is_br(lk_is_br),
      .lk_off(lk_off), .lk_taken(lk_taken), .lk_next_pc(lk_next_pc),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
   );

   typedef struct {
      logic [AW-1:0] npc;
      logic          tk;
      string         tag;
   } exp_t;

   exp_t  sbq[$];
   int    model[1 << IW];
   int    total = 0;
   int    bad = 0;
   bit    done = 0;

   function automatic logic [AW-1:0] disp_of(input logic [OW-1:0] o);
      return {{(AW-OW-2){o[OW-1]}}, o, 2'b00};
   endfunction

   task automatic model_reset();
      for (int i = 0; i < (1 << IW); i++) model[i] = 1;
   endtask

   // Driver: one lookup plus optional update per cycle; predicts the result.
   task automatic step(input logic [AW-1:0] pc, input logic br, input logic [OW-1:0] off,
                       input logic uv, input logic [AW-1:0] upc, input logic ut,
                       input string tag);
      exp_t e;
      int   i;
      @(posedge clk); #2;
      lk_pc = pc; lk_is_br = br; lk_off = off;
      up_valid = uv; up_pc = upc; up_taken = ut;
      i = int'(pc[IW+1:2]);
      e.tk  = br && (model[i] >= 2);
      e.npc = e.tk ? pc + disp_of(off) : pc + 32'd4;
      e.tag = tag;
      sbq.push_back(e);
      if (uv) begin
         i = int'(upc[IW+1:2]);
         if (ut && model[i] < 3) model[i]++;
         else if (!ut && model[i] > 0) model[i]--;
      end
   endtask

   task automatic train(input logic [AW-1:0] pc, input logic ut, input string tag);
      step(pc, 1'b0, '0, 1'b1, pc, ut, tag);
   endtask

   task automatic probe(input logic [AW-1:0] pc, input logic [OW-1:0] off, input string tag);
      step(pc, 1'b1, off, 1'b0, '0, 1'b0, tag);
   endtask

   // Monitor: compares one scoreboard item per cycle, mid-cycle.
   initial begin
      forever begin
         @(negedge clk);
         if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            total++;
            if (lk_taken !== e.tk || lk_next_pc !== e.npc) begin
               bad++;
               $display("FAIL %s: got taken=%0b npc=%h expected taken=%0b npc=%h",
                        e.tag, lk_taken, lk_next_pc, e.tk, e.npc);
            end
         end
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   localparam logic [AW-1:0] PA = 32'h0000_0100;
   localparam logic [AW-1:0] PB = 32'h0000_0104;

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1: reset state, several entries
      probe(PA, 16'h0010, "R1 reset entry A");
      probe(32'h0000_2000, 16'h0010, "R1 reset other entry");
      probe(32'hFFFF_FFFC, 16'h0001, "R1 reset top entry");

      // R10 / R5 / R6: one taken step reaches weakly taken
      train(PA, 1'b1, "R10 train step");
      probe(PA, 16'h0010, "R5 R6 taken positive offset");
      probe(PA, 16'hFFF8, "R6 taken negative offset");
      step(PA, 1'b0, 16'h0010, 1'b0, '0, 1'b0, "R7 non-branch falls through");

      // R2: aliasing and low bits
      probe(PA + 32'h0000_4000, 16'h0010, "R2 alias above index");
      probe(PA | 32'h2, 16'h0010, "R2 low bits ignored");
      probe(PB, 16'h0010, "R10 neighbour untouched");

      // R3: saturate high then walk down
      for (int k = 0; k < 4; k++) train(PA, 1'b1, "R3 push to top");
      probe(PA, 16'h0020, "R3 at top");
      step(PA, 1'b1, 16'h0020, 1'b1, PA, 1'b0, "R9 R3 same-cycle dec sees top");
      probe(PA, 16'h0020, "R3 one below top still taken");
      train(PA, 1'b0, "R3 second dec");
      probe(PA, 16'h0020, "R3 R8 two below top not taken");

      // R10: ignored update when up_valid is low
      step(PA, 1'b0, '0, 1'b0, PA, 1'b1, "R10 strobe low");
      probe(PA, 16'h0020, "R10 ignored update left entry");

      // R4: saturate low
      for (int k = 0; k < 3; k++) train(PA, 1'b0, "R4 push to bottom");
      probe(PA, 16'h0004, "R4 at bottom");
      train(PA, 1'b1, "R4 one up from bottom");
      probe(PA, 16'h0004, "R4 one above bottom not taken");

      // R9: collision from weak not-taken
      step(PA, 1'b1, 16'h0008, 1'b1, PA, 1'b1, "R9 collision pre-update value");
      probe(PA, 16'h0008, "R9 update visible next cycle");
      probe(PB, 16'h0008, "R10 neighbour still weak");

      // R1: a later reset clears trained state
      @(posedge clk); #2;
      up_valid = 1'b0; lk_is_br = 1'b0; rst_n = 1'b0;
      model_reset();
      @(posedge clk); #2 rst_n = 1'b1;
      probe(PA, 16'h0008, "R1 after second reset");
      step('0, 1'b0, '0, 1'b0, '0, 1'b0, "R7 idle");

      wait (sbq.size() == 0);
      @(posedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule